// File: doc/BRIEF.md
# Streaming Line Prefetcher with Count-Keyed Processor Wake

This block fetches whole cache lines for a handful of linear arrays into a data cache while the processor rests in a low-power state. Software first describes each array by its base address and its length in elements. It then starts the stream. Later it asks to sleep until a chosen number of lines, `w`, has landed. The engine turns each array length into a count of lines and adds it to one shared remaining-lines counter. It then issues line-sized read requests to memory, visiting the arrays in turn, and subtracts one from the counter for every line that comes back.

The sleep request is guarded against deadlock. It is granted only when `w` is at least one and no larger than the number of lines still to arrive, so the wake condition is always reachable. Once granted, a wake counter counts returned lines down from `w`, and the processor is released on the last one. The block drives no interrupt or timer. Wake-up depends only on how many lines have returned.

Top module: `stream_prefetch_wake`

## Requirements
- R1: A setup command (`cmd_op` = 2'b01, `cmd_arg` = element count) adds ceil(elements / 8) to `lines_left` in the next cycle and takes the next free descriptor slot. Once all `NUM_ARR` slots are taken, further setup commands leave `lines_left` unchanged.
- R2: No memory request is raised before a start command (`cmd_op` = 2'b10). After start, requests continue with no further commands until every registered line has been requested.
- R3: Requests visit the registered arrays round-robin in slot order, one line per array per turn, and skip exhausted arrays. The k-th request to an array carries its base address (aligned down to 32 bytes) plus 32·k.
- R4: No more than `MAX_OUTST` requests are ever outstanding. While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged.
- R5: Each cycle with `mem_rsp_valid` high lowers `lines_left` by one.
- R6: An idle command (`cmd_op` = 2'b11, `cmd_arg` = w) raises `proc_sleep` in the next cycle only if 1 ≤ w ≤ `lines_left`. Otherwise the command is ignored and `proc_sleep` stays low.
- R7: `proc_sleep` falls in the cycle after the w-th line returned since the idle command was accepted. A line that returns in the same cycle as the accepted command counts toward w.
- R8: Setup commands that arrive after start are rejected and leave `lines_left` unchanged.
- R9: `done` is high exactly when the engine has started, `lines_left` is zero and no request is outstanding. Once high, it stays high until reset.
- R10: Synchronous reset clears the descriptors, `lines_left`, the wake counter and the outstanding count, and drives `proc_sleep`, `mem_req_valid` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 setup, 10 start, 11 idle, 00 none |
| cmd_base | input | ADDR_W | Array base byte address (setup) |
| cmd_arg | input | CNT_W | Element count (setup) or wake threshold w (idle) |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Line-aligned request address |
| mem_rsp_valid | input | 1 | One line returned this cycle |
| proc_sleep | output | 1 | Processor held in low-power state |
| lines_left | output | CNT_W+clog2(NUM_ARR) | Lines still to be returned |
| done | output | 1 | All registered lines fetched |

## Verification
The bench builds the block with `NUM_ARR` = 3, `MAX_OUTST` = 2 and `CNT_W` = 12. With these values a fourth setup reaches the full-table rejection and only two fetches are needed to hit the outstanding limit. The round-robin order is short enough to list in full. Three arrays of 3, 1 and 2 lines exercise skipping of exhausted slots. A stall with ready held low checks that the request is held, and a threshold of three returned lines checks the wake timing cycle by cycle.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_SETUP = 2'b01,
      OP_START = 2'b10,
      OP_IDLE  = 2'b11
   } pfw_op_e;
endpackage

// File: rtl/pfw_desc_table.sv
module pfw_desc_table #(
   parameter int ADDR_W         = 32,
   parameter int CNT_W          = 16,
   parameter int NUM_ARR        = 4,
   parameter int WORDS_PER_LINE = 8,
   parameter int BYTES_PER_WORD = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              setup_stb,
   input  logic              started,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  elems,
   input  logic              issue_fire,
   output logic              setup_acc,
   output logic [CNT_W-1:0]  setup_lines,
   output logic              any_pending,
   output logic [ADDR_W-1:0] req_addr
);
   localparam int LINE_BYTES = WORDS_PER_LINE * BYTES_PER_WORD;
   localparam int OFFS       = $clog2(LINE_BYTES);
   localparam int WSH        = $clog2(WORDS_PER_LINE);
   localparam int SEL_W      = $clog2(NUM_ARR);
   localparam int FILL_W     = $clog2(NUM_ARR + 1);

   generate
      if (NUM_ARR < 2) begin : g_bad_num
         $error("pfw_desc_table: NUM_ARR must be at least 2");
      end
      if ((1 << WSH) != WORDS_PER_LINE) begin : g_bad_words
         $error("pfw_desc_table: WORDS_PER_LINE must be a power of two");
      end
      if ((1 << OFFS) != LINE_BYTES) begin : g_bad_line
         $error("pfw_desc_table: line size must be a power of two");
      end
   endgenerate

   logic [FILL_W-1:0] fill_cnt;
   logic [SEL_W-1:0]  rr_q;
   logic [SEL_W-1:0]  sel;
   logic              found;
   logic [NUM_ARR-1:0] pend;
   logic [ADDR_W-1:0] cur_addr [NUM_ARR];
   logic [CNT_W:0]    round_up;

   assign round_up    = {1'b0, elems} + (CNT_W + 1)'(WORDS_PER_LINE - 1);
   assign setup_lines = CNT_W'(round_up >> WSH);
   assign setup_acc   = setup_stb && !started && (fill_cnt < FILL_W'(NUM_ARR));

   always_ff @(posedge clk) begin
      if (rst) fill_cnt <= '0;
      else if (setup_acc) fill_cnt <= fill_cnt + 1'b1;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_ARR; gi++) begin : g_slot
         logic [ADDR_W-1:0] addr_q;
         logic [CNT_W-1:0]  left_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               addr_q <= '0;
               left_q <= '0;
            end else if (setup_acc && (fill_cnt == FILL_W'(gi))) begin
               addr_q <= {base[ADDR_W-1:OFFS], {OFFS{1'b0}}};
               left_q <= setup_lines;
            end else if (issue_fire && (sel == SEL_W'(gi))) begin
               addr_q <= addr_q + ADDR_W'(LINE_BYTES);
               left_q <= left_q - 1'b1;
            end
         end
         assign pend[gi]     = (left_q != '0);
         assign cur_addr[gi] = addr_q;
      end
   endgenerate

   always_comb begin
      int idx;
      sel   = rr_q;
      found = 1'b0;
      for (int k = 0; k < NUM_ARR; k++) begin
         idx = int'(rr_q) + k;
         if (idx >= NUM_ARR) idx = idx - NUM_ARR;
         if (!found && pend[idx]) begin
            found = 1'b1;
            sel   = SEL_W'(idx);
         end
      end
   end

   assign any_pending = found;
   assign req_addr    = cur_addr[sel];

   always_ff @(posedge clk) begin
      if (rst) rr_q <= '0;
      else if (issue_fire) rr_q <= (sel == SEL_W'(NUM_ARR - 1)) ? '0 : sel + 1'b1;
   end

   AST_ADDR_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      any_pending |-> (req_addr[OFFS-1:0] == '0)); // R3
   AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      started |=> $stable(fill_cnt)); // R8
endmodule

// File: rtl/pfw_line_counter.sv
module pfw_line_counter #(
   parameter int CNT_W     = 16,
   parameter int LEFT_W    = 18,
   parameter int MAX_OUTST = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              started,
   input  logic              add_stb,
   input  logic [CNT_W-1:0]  add_lines,
   input  logic              issue_fire,
   input  logic              rsp,
   output logic [LEFT_W-1:0] lines_left,
   output logic              can_issue,
   output logic              done
);
   localparam int OUT_W = $clog2(MAX_OUTST + 1);

   generate
      if (MAX_OUTST < 1) begin : g_bad_outst
         $error("pfw_line_counter: MAX_OUTST must be at least 1");
      end
      if (LEFT_W < CNT_W) begin : g_bad_left
         $error("pfw_line_counter: LEFT_W narrower than CNT_W");
      end
   endgenerate

   logic [OUT_W-1:0] outst;

   always_ff @(posedge clk) begin
      if (rst) begin
         lines_left <= '0;
         outst      <= '0;
      end else begin
         lines_left <= lines_left + (add_stb ? LEFT_W'(add_lines) : '0)
                       - LEFT_W'(rsp);
         outst      <= outst + OUT_W'(issue_fire) - OUT_W'(rsp);
      end
   end

   assign can_issue = (outst < OUT_W'(MAX_OUTST));
   assign done      = started && (lines_left == '0) && (outst == '0);

   AST_OUTST_LIMIT: assert property (@(posedge clk) disable iff (rst)
      outst <= OUT_W'(MAX_OUTST)); // R4
   AST_LEFT_COVERS_OUTST: assert property (@(posedge clk) disable iff (rst)
      LEFT_W'(outst) <= lines_left); // R5
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      done |=> done); // R9
endmodule

// File: rtl/pfw_wake_ctrl.sv
module pfw_wake_ctrl #(
   parameter int CNT_W  = 16,
   parameter int LEFT_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              idle_stb,
   input  logic [CNT_W-1:0]  thresh,
   input  logic [LEFT_W-1:0] lines_left,
   input  logic              rsp,
   output logic              sleep
);
   logic [CNT_W-1:0] wake_cnt;
   logic [CNT_W-1:0] load_val;
   logic             accept;

   assign accept   = idle_stb && !sleep && (thresh != '0)
                     && (LEFT_W'(thresh) <= lines_left);
   assign load_val = thresh - CNT_W'(rsp);

   always_ff @(posedge clk) begin
      if (rst) begin
         sleep    <= 1'b0;
         wake_cnt <= '0;
      end else if (accept) begin
         sleep    <= (load_val != '0);
         wake_cnt <= load_val;
      end else if (sleep && rsp) begin
         wake_cnt <= wake_cnt - 1'b1;
         if (wake_cnt == CNT_W'(1)) sleep <= 1'b0;
      end
   end

   AST_WAKE_REACHABLE: assert property (@(posedge clk) disable iff (rst)
      sleep |-> (wake_cnt != '0) && (LEFT_W'(wake_cnt) <= lines_left)); // R7
   AST_WAKE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
      (sleep && rsp && (wake_cnt == CNT_W'(1))) |=> !sleep); // R7
   AST_REFUSE_EXCESS: assert property (@(posedge clk) disable iff (rst)
      (idle_stb && !sleep && (LEFT_W'(thresh) > lines_left)) |=> !sleep); // R6
endmodule

// File: rtl/stream_prefetch_wake.sv
module stream_prefetch_wake #(
   parameter int ADDR_W         = 32,
   parameter int CNT_W          = 16,
   parameter int NUM_ARR        = 4,
   parameter int MAX_OUTST      = 4,
   parameter int WORDS_PER_LINE = 8,
   parameter int BYTES_PER_WORD = 4,
   localparam int LEFT_W        = CNT_W + $clog2(NUM_ARR)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [CNT_W-1:0]  cmd_arg,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   output logic              proc_sleep,
   output logic [LEFT_W-1:0] lines_left,
   output logic              done
);
   import pfw_pkg::*;

   logic             started;
   logic             setup_stb, idle_stb;
   logic             setup_acc;
   logic [CNT_W-1:0] setup_lines;
   logic             any_pending;
   logic             can_issue;
   logic             issue_fire;

   assign setup_stb = cmd_valid && (cmd_op == OP_SETUP);
   assign idle_stb  = cmd_valid && (cmd_op == OP_IDLE);

   always_ff @(posedge clk) begin
      if (rst) started <= 1'b0;
      else if (cmd_valid && (cmd_op == OP_START)) started <= 1'b1;
   end

   assign mem_req_valid = started && any_pending && can_issue;
   assign issue_fire    = mem_req_valid && mem_req_ready;

   pfw_desc_table #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_ARR(NUM_ARR),
      .WORDS_PER_LINE(WORDS_PER_LINE), .BYTES_PER_WORD(BYTES_PER_WORD)
   ) u_table (
      .clk(clk), .rst(rst), .setup_stb(setup_stb), .started(started),
      .base(cmd_base), .elems(cmd_arg), .issue_fire(issue_fire),
      .setup_acc(setup_acc), .setup_lines(setup_lines),
      .any_pending(any_pending), .req_addr(mem_req_addr)
   );

   pfw_line_counter #(
      .CNT_W(CNT_W), .LEFT_W(LEFT_W), .MAX_OUTST(MAX_OUTST)
   ) u_count (
      .clk(clk), .rst(rst), .started(started), .add_stb(setup_acc),
      .add_lines(setup_lines), .issue_fire(issue_fire), .rsp(mem_rsp_valid),
      .lines_left(lines_left), .can_issue(can_issue), .done(done)
   );

   pfw_wake_ctrl #(
      .CNT_W(CNT_W), .LEFT_W(LEFT_W)
   ) u_wake (
      .clk(clk), .rst(rst), .idle_stb(idle_stb), .thresh(cmd_arg),
      .lines_left(lines_left), .rsp(mem_rsp_valid), .sleep(proc_sleep)
   );

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)); // R4
   AST_REQ_HAS_LINES: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> (lines_left != '0)); // R2
endmodule

// File: tb/stream_prefetch_wake_tb.sv
module stream_prefetch_wake_tb;
   localparam int AW = 32;
   localparam int CW = 12;
   localparam int NA = 3;
   localparam int MO = 2;
   localparam int LW = CW + 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_base = '0;
   logic [CW-1:0] cmd_arg = '0;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic          proc_sleep;
   logic [LW-1:0] lines_left;
   logic          done;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit finished = 1'b0;

   bit rsp_en = 1'b0;
   int pending = 0;
   int consumed = 0;
   int n_log = 0;
   logic [AW-1:0] addr_log [16];

   always #5 clk = ~clk;

   stream_prefetch_wake #(
      .ADDR_W(AW), .CNT_W(CW), .NUM_ARR(NA), .MAX_OUTST(MO)
   ) u_dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_base(cmd_base), .cmd_arg(cmd_arg), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .proc_sleep(proc_sleep),
      .lines_left(lines_left), .done(done)
   );

   // memory model: acts 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst) begin
            pending = 0; consumed = 0; n_log = 0; mem_rsp_valid = 1'b0;
         end else begin
            if (mem_rsp_valid) consumed++;
            if (rsp_en && pending > 0) begin
               mem_rsp_valid = 1'b1;
               pending--;
            end else begin
               mem_rsp_valid = 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
               if (n_log < 16) addr_log[n_log] = mem_req_addr;
               n_log++;
               pending++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] b, input logic [CW-1:0] a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_base = b; cmd_arg = a;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // setup vectors: base, element count, expected lines_left afterwards
   localparam logic [AW-1:0] V_BASE [4] = '{32'h1000, 32'h2004, 32'h3000, 32'h4000};
   localparam logic [CW-1:0] V_ELEM [4] = '{12'd20, 12'd8, 12'd9, 12'd16};
   localparam logic [LW-1:0] V_LEFT [4] = '{14'd3, 14'd4, 14'd6, 14'd6};
   localparam logic [AW-1:0] EXP_ORDER [6] =
      '{32'h1000, 32'h2000, 32'h3000, 32'h1020, 32'h3020, 32'h1040};

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         finish_run();
      end
   end

   initial begin
      int c0;
      logic [AW-1:0] held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #2;
      // R10: reset state
      chk(lines_left == 0, "R10 lines_left", lines_left, 0);
      chk(!proc_sleep && !mem_req_valid && !done, "R10 outputs",
          {proc_sleep, mem_req_valid, done}, 0);

      // R1: table walk, last vector overflows the table
      for (int i = 0; i < 4; i++) begin
         do_cmd(2'b01, V_BASE[i], V_ELEM[i]);
         #2;
         chk(lines_left == V_LEFT[i], "R1 setup", lines_left, V_LEFT[i]);
         chk(!mem_req_valid, "R2 no request before start", mem_req_valid, 0);
      end

      // R2/R4: start with memory stalled
      mem_req_ready = 1'b0;
      do_cmd(2'b10, '0, '0);
      #2;
      chk(mem_req_valid && mem_req_addr == 32'h1000, "R2 first request",
          mem_req_addr, 32'h1000);
      held = mem_req_addr;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #2;
         chk(mem_req_valid && mem_req_addr == held, "R4 stall hold", mem_req_addr, held);
      end
      chk(n_log == 0, "R4 no handshake while stalled", n_log, 0);

      // R4: outstanding limit with no responses
      @(negedge clk); mem_req_ready = 1'b1;
      repeat (6) @(negedge clk);
      #2;
      chk(n_log == MO, "R4 outstanding limit", n_log, MO);
      chk(lines_left == 6, "R5 no return yet", lines_left, 6);

      // R8: setup after start
      do_cmd(2'b01, 32'h5000, 12'd8);
      #2;
      chk(lines_left == 6, "R8 late setup rejected", lines_left, 6);

      // R6: refused idle requests
      do_cmd(2'b11, '0, 12'd7);
      #2;
      chk(!proc_sleep, "R6 w above remaining", proc_sleep, 0);
      do_cmd(2'b11, '0, 12'd0);
      #2;
      chk(!proc_sleep, "R6 w zero", proc_sleep, 0);
      do_cmd(2'b11, '0, 12'd3);
      #2;
      chk(proc_sleep, "R6 accepted idle", proc_sleep, 1);

      // R7/R5: wake after three returned lines
      c0 = consumed;
      rsp_en = 1'b1;
      while (consumed - c0 < 3) begin
         chk(proc_sleep, "R7 still asleep", proc_sleep, 1);
         @(negedge clk); #2;
      end
      chk(!proc_sleep, "R7 wake on third line", proc_sleep, 0);
      chk(lines_left == LW'(6 - (consumed - c0)), "R5 decrement",
          lines_left, 6 - (consumed - c0));

      // R9: completion
      for (int i = 0; i < 200 && !done; i++) begin
         @(negedge clk); #2;
      end
      chk(done, "R9 done", done, 1);
      chk(lines_left == 0, "R9 lines_left zero", lines_left, 0);
      chk(n_log == 6, "R2 all lines requested", n_log, 6);
      for (int i = 0; i < 6; i++)
         chk(addr_log[i] == EXP_ORDER[i], "R3 order", addr_log[i], EXP_ORDER[i]);
      repeat (3) @(negedge clk);
      #2;
      chk(done, "R9 done holds", done, 1);

      // R6: idle with nothing left
      do_cmd(2'b11, '0, 12'd1);
      #2;
      chk(!proc_sleep, "R6 nothing left", proc_sleep, 0);

      // R10: reset after completion
      @(negedge clk); rst = 1'b1; rsp_en = 1'b0;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      #2;
      chk(!done && lines_left == 0 && !mem_req_valid, "R10 second reset",
          {done, mem_req_valid}, 0);
      finish_run();
   end
endmodule